// File: doc/BRIEF.md
# Dual-Order Burst Address Generator

This block sits beside a synchronous burst memory array. It turns one starting address into the word addresses of a short burst. Either of two active-low load strobes captures the full address presented on the bus. One strobe belongs to the processor and the other to a cache controller. After the load, an active-low advance input steps through the remaining beats, one step per clock edge. Only the low burst bits move. The bits above them keep the captured value until the next load.

The order of the low bits is chosen at run time by a mode input. In linear order the low bits count up from the start value and wrap inside the group. In interleaved order they are the start value XOR the beat count. Internally the block keeps the start value and the beat count in separate registers, and the address is formed from the two. A processor load is honoured only while the first chip enable is asserted (low). If both strobes are asserted in the same cycle, the processor strobe wins. A load in the same cycle as advance wins over advance. When the final beat has been issued and advance is asserted again, a single-cycle wrap flag is raised.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, `addr_out`, `beat_pos` and `wrap_pulse` are all zero.
- R2: A low `ctl_ld_n` at a clock edge loads the address, whatever the level of `en1_n`. After that edge, `addr_out` equals the `addr_in` that was sampled and `beat_pos` is 0.
- R3: A low `cpu_ld_n` at a clock edge loads the address only while `en1_n` is low. With `en1_n` high and `ctl_ld_n` high, the strobe has no effect and `addr_out` is unchanged after the edge. With both strobes low, exactly one load of `addr_in` occurs.
- R4: With `ilv_mode` = 0 (linear), the low two bits of `addr_out` equal (start + `beat_pos`) mod 4. For a start of 01 the sequence is 01, 10, 11, 00.
- R5: With `ilv_mode` = 1 (interleaved), the low two bits of `addr_out` equal start XOR `beat_pos`. For a start of 01 the sequence is 01, 00, 11, 10.
- R6: With no load, a low `adv_n` at an edge raises `beat_pos` by one, modulo 4. A high `adv_n` holds `beat_pos` and `addr_out` (suspend).
- R7: Between loads, `addr_out[ADDR_W-1:2]` never changes, including across a wrap.
- R8: A load at the same edge as a low `adv_n` leaves `beat_pos` at 0 and `addr_out` at the loaded address. No wrap flag is raised.
- R9: `wrap_pulse` is high for exactly the one cycle after an edge at which `beat_pos` was 3, `adv_n` was low and no load occurred. At that edge `beat_pos` returns to 0.
- R10: A change of `ilv_mode` changes the low bits of `addr_out` within the same cycle, without a clock edge. `beat_pos` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ld_n | input | 1 | Processor load strobe, active low, gated by `en1_n` |
| ctl_ld_n | input | 1 | Controller load strobe, active low |
| en1_n | input | 1 | First chip enable, active low; masks the processor strobe |
| adv_n | input | 1 | Advance, active low |
| ilv_mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr_in | input | ADDR_W | Address bus sampled on a load |
| addr_out | output | ADDR_W | Current word address |
| beat_pos | output | BEAT_W | Beats advanced since the last load |
| wrap_pulse | output | 1 | One-cycle flag after the burst wraps |

## Verification
A wrong beat count shows at the ports on the edge right after it goes wrong. The low address bits and `beat_pos` disagree with the expected sequence at once, in both orders. A corrupted start register shows as a constant offset on every later beat until the next load. A corrupted upper register shows as a change of the high bits with no load before it. A wrong wrap decision shows one cycle after the fourth advance, either as a missing pulse or as a pulse after a load. A fault in the mode path shows combinationally, before the next edge.

// File: rtl/bag_pkg.sv
package bag_pkg;
   // Which burst orders the generator builds
   typedef enum logic [1:0] {
      ORD_RUNTIME    = 2'd0,  // both orders, chosen by ilv_mode
      ORD_LINEAR     = 2'd1,  // linear only, ilv_mode ignored
      ORD_INTERLEAVE = 2'd2   // interleaved only, ilv_mode ignored
   } bag_order_e;
endpackage

// File: rtl/bag_load_arb.sv
module bag_load_arb (
   input  logic cpu_ld_n,
   input  logic ctl_ld_n,
   input  logic en1_n,
   output logic load_en
);
   logic cpu_take;
   logic ctl_take;

   // processor strobe is masked by the first chip enable
   always_comb begin
      cpu_take = ~cpu_ld_n & ~en1_n;
      // controller is honoured only when the processor is not
      ctl_take = ~ctl_ld_n & ~cpu_take;
      load_en  = cpu_take | ctl_take;
   end
endmodule

// File: rtl/bag_addr_hold.sv
module bag_addr_hold #(
   parameter int ADDR_W = 18,
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] base_q,
   output logic [BEAT_W-1:0] start_q
);
   localparam int UP_W = ADDR_W - BEAT_W;

   logic [UP_W-1:0] upper_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upper_q <= '0;
         start_q <= '0;
      end else if (load_en) begin
         upper_q <= addr_in[ADDR_W-1:BEAT_W];
         start_q <= addr_in[BEAT_W-1:0];
      end
   end

   assign base_q = {upper_q, {BEAT_W{1'b0}}};
endmodule

// File: rtl/bag_beat_step.sv
module bag_beat_step #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic              adv_n,
   output logic [BEAT_W-1:0] step_q,
   output logic              wrap_q
);
   localparam logic [BEAT_W-1:0] LAST = {BEAT_W{1'b1}};

   logic adv_take;
   assign adv_take = ~load_en & ~adv_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
         wrap_q <= 1'b0;
      end else begin
         wrap_q <= adv_take & (step_q == LAST);
         if (load_en)
            step_q <= '0;
         else if (adv_take)
            step_q <= step_q + 1'b1;
      end
   end
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
   import bag_pkg::*;
#(
   parameter int         BEAT_W    = 2,
   parameter bag_order_e ORDER_SEL = ORD_RUNTIME
) (
   input  logic [BEAT_W-1:0] start_q,
   input  logic [BEAT_W-1:0] step_q,
   input  logic              ilv_mode,
   output logic [BEAT_W-1:0] low_bits
);
   logic [BEAT_W-1:0] lin_bits;
   logic [BEAT_W-1:0] ilv_bits;

   always_comb begin
      lin_bits = start_q + step_q;
      ilv_bits = start_q ^ step_q;
   end

   generate
      if (ORDER_SEL == ORD_LINEAR) begin : g_lin
         logic unused_mode;
         assign unused_mode = ilv_mode ^ (^ilv_bits);
         assign low_bits = lin_bits;
      end else if (ORDER_SEL == ORD_INTERLEAVE) begin : g_ilv
         logic unused_mode;
         assign unused_mode = ilv_mode ^ (^lin_bits);
         assign low_bits = ilv_bits;
      end else begin : g_both
         assign low_bits = ilv_mode ? ilv_bits : lin_bits;
      end
   endgenerate
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import bag_pkg::*;
#(
   parameter int         ADDR_W    = 18,
   parameter int         BEAT_W    = 2,
   parameter bag_order_e ORDER_SEL = ORD_RUNTIME
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_ld_n,
   input  logic              ctl_ld_n,
   input  logic              en1_n,
   input  logic              adv_n,
   input  logic              ilv_mode,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out,
   output logic [BEAT_W-1:0] beat_pos,
   output logic              wrap_pulse
);
   generate
      if (BEAT_W < 1) begin : g_bad_beat
         $error("burst_addr_gen: BEAT_W must be at least 1");
      end
      if (ADDR_W <= BEAT_W) begin : g_bad_addr
         $error("burst_addr_gen: ADDR_W must exceed BEAT_W");
      end
   endgenerate

   logic              load_en;
   logic [ADDR_W-1:0] base_q;
   logic [BEAT_W-1:0] start_q;
   logic [BEAT_W-1:0] step_q;
   logic [BEAT_W-1:0] low_bits;
   logic              wrap_q;

   bag_load_arb u_arb (
      .cpu_ld_n (cpu_ld_n),
      .ctl_ld_n (ctl_ld_n),
      .en1_n    (en1_n),
      .load_en  (load_en)
   );

   bag_addr_hold #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (load_en),
      .addr_in (addr_in),
      .base_q  (base_q),
      .start_q (start_q)
   );

   bag_beat_step #(.BEAT_W(BEAT_W)) u_step (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (load_en),
      .adv_n   (adv_n),
      .step_q  (step_q),
      .wrap_q  (wrap_q)
   );

   bag_order_map #(.BEAT_W(BEAT_W), .ORDER_SEL(ORDER_SEL)) u_map (
      .start_q  (start_q),
      .step_q   (step_q),
      .ilv_mode (ilv_mode),
      .low_bits (low_bits)
   );

   assign addr_out   = {base_q[ADDR_W-1:BEAT_W], low_bits};
   assign beat_pos   = step_q;
   assign wrap_pulse = wrap_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
   import bag_pkg::*;
#(
   parameter int         ADDR_W    = 18,
   parameter int         BEAT_W    = 2,
   parameter bag_order_e ORDER_SEL = ORD_RUNTIME
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_ld_n,
   input logic              ctl_ld_n,
   input logic              en1_n,
   input logic              adv_n,
   input logic              ilv_mode,
   input logic [ADDR_W-1:0] addr_in,
   input logic [ADDR_W-1:0] addr_out,
   input logic [BEAT_W-1:0] beat_pos,
   input logic              wrap_pulse
);
   localparam logic [BEAT_W-1:0] LAST = {BEAT_W{1'b1}};
   localparam bit RT = (ORDER_SEL == ORD_RUNTIME);

   logic              ld;
   logic [BEAT_W-1:0] lo;
   logic [BEAT_W-1:0] nxt_beat;
   assign ld       = (~cpu_ld_n & ~en1_n) | ~ctl_ld_n;
   assign lo       = addr_out[BEAT_W-1:0];
   assign nxt_beat = beat_pos + 1'b1;

   p_reset_zero_r1: assert property (@(posedge clk)
      !rst_n |-> (addr_out == '0 && beat_pos == '0 && !wrap_pulse));

   p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (addr_out == $past(addr_in) && beat_pos == '0));

   p_cpu_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_ld_n && en1_n && ctl_ld_n && adv_n) |=>
         (!$stable(ilv_mode) || $stable(addr_out)));

   p_ilv_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (RT && !ld && ilv_mode) |=>
         (!ilv_mode || ((lo ^ beat_pos) == $past(lo ^ beat_pos))));

   p_lin_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (RT && !ld && !ilv_mode) |=>
         (ilv_mode || ((lo - beat_pos) == $past(lo - beat_pos))));

   p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !adv_n) |=> (beat_pos == $past(nxt_beat)));

   p_suspend_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && adv_n) |=> $stable(beat_pos));

   p_upper_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

   p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !adv_n) |=> (beat_pos == '0 && !wrap_pulse));

   p_wrap_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !adv_n && beat_pos == LAST) |=> (wrap_pulse && beat_pos == '0));

   p_wrap_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_pulse |=> !wrap_pulse);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(
   .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .ORDER_SEL(ORDER_SEL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_ld_n   (cpu_ld_n),
   .ctl_ld_n   (ctl_ld_n),
   .en1_n      (en1_n),
   .adv_n      (adv_n),
   .ilv_mode   (ilv_mode),
   .addr_in    (addr_in),
   .addr_out   (addr_out),
   .beat_pos   (beat_pos),
   .wrap_pulse (wrap_pulse)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 18;
   localparam int NV = 17;

   typedef struct packed {
      logic [3:0]    req;
      logic          cpu_n, ctl_n, en1_n, adv_n, mode;
      logic [AW-1:0] ain;
      logic [AW-1:0] eout;
      logic [1:0]    ebeat;
      logic          ewrap;
   } vec_t;

   // fields: req, cpu_n, ctl_n, en1_n, adv_n, mode, ain, eout, ebeat, ewrap
   localparam vec_t TBL [NV] = '{
      '{4'd2, 1'b1,1'b0,1'b1,1'b1,1'b0, 18'h2A5C1, 18'h2A5C1, 2'd0, 1'b0}, // R2
      '{4'd4, 1'b1,1'b1,1'b1,1'b0,1'b0, 18'h00000, 18'h2A5C2, 2'd1, 1'b0}, // R4
      '{4'd4, 1'b1,1'b1,1'b1,1'b0,1'b0, 18'h00000, 18'h2A5C3, 2'd2, 1'b0}, // R4
      '{4'd6, 1'b1,1'b1,1'b1,1'b1,1'b0, 18'h00000, 18'h2A5C3, 2'd2, 1'b0}, // R6
      '{4'd7, 1'b1,1'b1,1'b1,1'b0,1'b0, 18'h00000, 18'h2A5C0, 2'd3, 1'b0}, // R7
      '{4'd9, 1'b1,1'b1,1'b1,1'b0,1'b0, 18'h00000, 18'h2A5C1, 2'd0, 1'b1}, // R9
      '{4'd5, 1'b1,1'b1,1'b1,1'b1,1'b1, 18'h00000, 18'h2A5C1, 2'd0, 1'b0}, // R5
      '{4'd5, 1'b1,1'b1,1'b1,1'b0,1'b1, 18'h00000, 18'h2A5C0, 2'd1, 1'b0}, // R5
      '{4'd5, 1'b1,1'b1,1'b1,1'b0,1'b1, 18'h00000, 18'h2A5C3, 2'd2, 1'b0}, // R5
      '{4'd5, 1'b1,1'b1,1'b1,1'b0,1'b1, 18'h00000, 18'h2A5C2, 2'd3, 1'b0}, // R5
      '{4'd8, 1'b0,1'b1,1'b0,1'b0,1'b1, 18'h1337E, 18'h1337E, 2'd0, 1'b0}, // R8
      '{4'd3, 1'b0,1'b1,1'b1,1'b1,1'b1, 18'h00003, 18'h1337E, 2'd0, 1'b0}, // R3
      '{4'd3, 1'b0,1'b0,1'b1,1'b1,1'b0, 18'h00003, 18'h00003, 2'd0, 1'b0}, // R3
      '{4'd4, 1'b1,1'b1,1'b1,1'b0,1'b0, 18'h00000, 18'h00000, 2'd1, 1'b0}, // R4
      '{4'd6, 1'b1,1'b1,1'b1,1'b0,1'b0, 18'h00000, 18'h00001, 2'd2, 1'b0}, // R6
      '{4'd7, 1'b1,1'b1,1'b1,1'b0,1'b0, 18'h00000, 18'h00002, 2'd3, 1'b0}, // R7
      '{4'd8, 1'b1,1'b0,1'b1,1'b0,1'b0, 18'h3FFFF, 18'h3FFFF, 2'd0, 1'b0}  // R8
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_ld_n = 1'b1;
   logic          ctl_ld_n = 1'b1;
   logic          en1_n = 1'b1;
   logic          adv_n = 1'b1;
   logic          ilv_mode = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] addr_out;
   logic [1:0]    beat_pos;
   logic          wrap_pulse;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_ld_n   (cpu_ld_n),
      .ctl_ld_n   (ctl_ld_n),
      .en1_n      (en1_n),
      .adv_n      (adv_n),
      .ilv_mode   (ilv_mode),
      .addr_in    (addr_in),
      .addr_out   (addr_out),
      .beat_pos   (beat_pos),
      .wrap_pulse (wrap_pulse)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 2000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      // R1: outputs are zero while reset is held
      repeat (2) @(negedge clk);
      chk("R1", "addr_out", 32'(addr_out), 32'h0);
      chk("R1", "beat_pos", 32'(beat_pos), 32'h0);
      chk("R1", "wrap", 32'(wrap_pulse), 32'h0);
      rst_n = 1'b1;

      // table walk: drive at a falling edge, check at the next falling edge
      for (int i = 0; i < NV; i++) begin
         string tag;
         tag      = $sformatf("R%0d", TBL[i].req);
         cpu_ld_n = TBL[i].cpu_n;
         ctl_ld_n = TBL[i].ctl_n;
         en1_n    = TBL[i].en1_n;
         adv_n    = TBL[i].adv_n;
         ilv_mode = TBL[i].mode;
         addr_in  = TBL[i].ain;
         @(negedge clk);
         chk(tag, $sformatf("vec%0d addr", i), 32'(addr_out), 32'(TBL[i].eout));
         chk(tag, $sformatf("vec%0d beat", i), 32'(beat_pos), 32'(TBL[i].ebeat));
         chk(tag, $sformatf("vec%0d wrap", i), 32'(wrap_pulse), 32'(TBL[i].ewrap));
      end

      // R10: mode switch mid-burst acts without a clock edge
      cpu_ld_n = 1'b1; ctl_ld_n = 1'b1; adv_n = 1'b0; ilv_mode = 1'b0;
      @(negedge clk);
      adv_n = 1'b1;
      chk("R4", "linear wrap low", 32'(addr_out), 32'h3FFFC);
      #1 ilv_mode = 1'b1;
      #1;
      chk("R10", "mode flip addr", 32'(addr_out), 32'h3FFFE);
      chk("R10", "mode flip beat", 32'(beat_pos), 32'h1);

      // R1: asynchronous reset in the middle of a burst
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1", "mid reset addr", 32'(addr_out), 32'h0);
      chk("R1", "mid reset beat", 32'(beat_pos), 32'h0);
      chk("R1", "mid reset wrap", 32'(wrap_pulse), 32'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule